// File: doc/BRIEF.md
# Converter Mode and Self-Calibration Sequencer

This block owns the configuration word of a precision digital-to-analog converter and puts its mode field into effect. A serial front end delivers register traffic one byte at a time as a write strobe, a byte address and a data byte. The block keeps the 16-bit command word, the 24-bit data word and two 24-bit correction words: offset and full-scale gain. Each byte write takes effect on the clock edge that carries its strobe. The command byte also carries pulse-style actions: it can clear the data word and it can zero the correction words.

A normal, sleep or self-calibration state is chosen through the two mode bits. Self-calibration runs as a timed sequence against an external measurement path, which is reached through two valid/ready channels. First the offset correction is cleared. After a settle wait, a fixed power-of-two number of offset comparisons is taken and averaged as signed values. After a second settle wait, the same number of gain comparisons is averaged as unsigned values. The write lockout flag stays high from the start request until the end of the sequence, and every register write is dropped while it is high. When the sequence ends, the mode bits read back as normal.

The request channel asserts `req_valid_o` with `req_phase_o` and holds both unchanged until `req_ready_i` is seen high on a clock edge. The result channel offers `res_ready_o` only while it waits for a comparison result. A result is taken on an edge where `res_valid_i` and `res_ready_o` are both high. The measurement side may stall either channel for any number of cycles. One result is expected for each accepted request.

Top module: `cal_sequencer`

## Requirements
- R1: After reset, the command, data, offset and gain words read zero, the mode is 00, and the lock and sleep flags are low.
- R2: A byte write takes effect on the edge of its strobe. The address map is: address 0 is command bits 7:0, address 1 is command bits 15:8, addresses 2..4 are the data word, 5..7 the offset word and 8..10 the gain word, least significant byte first. Addresses 11..15 change nothing.
- R3: Command bits 1:0 are the mode (00 normal, 01 self-calibration, 10 sleep, 11 treated as normal). Writing mode 01 together with sample/hold bit 4 set raises the lock flag from the next cycle, and the mode reads 01. Writing 01 with bit 4 clear stores mode 00 and starts nothing.
- R4: While the lock flag is high, every register write is ignored, including command writes.
- R5: A calibration first zeroes the offset word. It then issues 2^AVG_LOG requests with phase 0 (offset), followed by 2^AVG_LOG requests with phase 1 (gain), with a settle wait of CAL_SETTLE cycles before each phase.
- R6: The stored offset is the two's-complement sum of the signed offset results shifted arithmetically right by AVG_LOG, which rounds toward minus infinity.
- R7: The stored gain is the unsigned sum of the gain results shifted right by AVG_LOG, whatever the sign bit of each result.
- R8: When calibration ends, the mode reads 00 and the lock flag falls on the same edge. Bit 4 and the other command bits keep their values.
- R9: The sleep flag is high exactly while the mode reads 10. Writes are accepted during sleep. Sleep is left only by writing a mode other than 10.
- R10: While clear bit 2 is set, the data word reads zero and data byte writes are ignored. Setting the bit zeroes the data word on that write's edge.
- R11: Writing the command low byte with bit 3 set zeroes both correction words. Bit 3 always reads back 0.
- R12: A pending request keeps its valid and phase stable until accepted. A result is consumed only while the ready signal is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe from the serial port |
| wr_addr | input | 4 | Byte address of the write |
| wr_data | input | 8 | Byte to write |
| cmd_o | output | 16 | Command word |
| mode_o | output | 2 | Mode field status |
| lock_o | output | 1 | Write lockout (calibration in progress) |
| sleep_o | output | 1 | Sleep flag |
| data_o | output | 24 | Data word |
| ofs_o | output | 24 | Offset correction word (two's complement) |
| gain_o | output | 24 | Gain correction word (unsigned) |
| req_valid_o | output | 1 | Comparison request valid |
| req_ready_i | input | 1 | Comparison request accepted |
| req_phase_o | output | 1 | Request phase: 0 offset, 1 gain |
| res_valid_i | input | 1 | Comparison result valid |
| res_ready_o | output | 1 | Block ready to take a result |
| res_data_i | input | 24 | Comparison result word |

## Verification
A stuck sequencer state shows up at once as a lock flag that never falls, or as requests that are out of phase order or too many. The scoreboard catches these when each request is accepted. A bad accumulator or a wrong sign treatment does not show until the end of a phase, and then only as a wrong offset or gain word. Two calibration rounds are therefore run, with negative offset samples and with gain samples whose top bit is set. A lock that leaks writes is exposed after completion, when the data, command and sleep state are compared with their values from before the sequence.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  localparam logic [1:0] MODE_NORMAL = 2'b00;
  localparam logic [1:0] MODE_CAL    = 2'b01;
  localparam logic [1:0] MODE_SLEEP  = 2'b10;

  localparam int BIT_CLR  = 2;
  localparam int BIT_CRST = 3;
  localparam int BIT_SH   = 4;

  typedef enum logic [2:0] {
    CS_IDLE, CS_CLEAR, CS_SETTLE, CS_REQ, CS_WAIT, CS_STORE
  } cal_state_e;
endpackage

// File: rtl/cal_regfile.sv
module cal_regfile
  import cal_seq_pkg::*;
#(
  parameter int AW     = 4,
  parameter int CMD_W  = 16,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              lock,
  input  logic              cal_done,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [DATA_W-1:0] data_q,
  output logic              cal_start,
  output logic [DATA_W/8-1:0] ofs_we,
  output logic [DATA_W/8-1:0] gain_we,
  output logic              cal_rst
);
  localparam int NB        = DATA_W / 8;
  localparam int DATA_BASE = 2;
  localparam int OFS_BASE  = DATA_BASE + NB;
  localparam int GAIN_BASE = OFS_BASE + NB;

  logic              wr_ok;
  logic [NB-1:0]     data_we;
  logic [1:0]        new_mode;

  assign wr_ok = wr_en && !lock;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign data_we[b] = wr_ok && (wr_addr == AW'(DATA_BASE + b));
    assign ofs_we[b]  = wr_ok && (wr_addr == AW'(OFS_BASE + b));
    assign gain_we[b] = wr_ok && (wr_addr == AW'(GAIN_BASE + b));
  end

  assign cal_rst  = wr_ok && (wr_addr == AW'(0)) && wr_data[BIT_CRST];
  assign new_mode = (wr_data[1:0] == MODE_CAL && !wr_data[BIT_SH]) ? MODE_NORMAL
                                                                   : wr_data[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      data_q    <= '0;
      cal_start <= 1'b0;
    end else begin
      cal_start <= 1'b0;
      if (cal_done) cmd_q[1:0] <= MODE_NORMAL;
      if (wr_ok && wr_addr == AW'(0)) begin
        cmd_q[7:0] <= {wr_data[7:4], 1'b0, wr_data[BIT_CLR], new_mode};
        cal_start  <= (wr_data[1:0] == MODE_CAL) && wr_data[BIT_SH];
        if (wr_data[BIT_CLR]) data_q <= '0;
      end
      if (wr_ok && wr_addr == AW'(1)) cmd_q[CMD_W-1:8] <= wr_data[CMD_W-9:0];
      if (!cmd_q[BIT_CLR]) begin
        for (int b = 0; b < NB; b++)
          if (data_we[b]) data_q[8*b +: 8] <= wr_data;
      end
    end
  end

  p_locked_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && wr_en && !cal_done) |=> ($stable(data_q) && $stable(cmd_q)));
  p_clear_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[BIT_CLR] |-> (data_q == '0));
  p_done_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> (cmd_q[1:0] == MODE_NORMAL));
  p_crst_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_q[BIT_CRST]);
endmodule

// File: rtl/cal_accum.sv
module cal_accum #(
  parameter int DATA_W  = 24,
  parameter int AVG_LOG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add_en,
  input  logic              signed_mode,
  input  logic [DATA_W-1:0] sample,
  output logic [DATA_W-1:0] avg
);
  localparam int ACC_W = DATA_W + AVG_LOG;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] ext;
  logic [ACC_W-1:0] shifted;

  assign ext = signed_mode ? {{AVG_LOG{sample[DATA_W-1]}}, sample}
                           : {{AVG_LOG{1'b0}}, sample};

  always_comb begin
    if (signed_mode) shifted = ACC_W'($signed(acc_q) >>> AVG_LOG);
    else             shifted = acc_q >> AVG_LOG;
  end
  assign avg = shifted[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (clr)    acc_q <= '0;
    else if (add_en) acc_q <= acc_q + ext;
  end
endmodule

// File: rtl/cal_fsm.sv
module cal_fsm
  import cal_seq_pkg::*;
#(
  parameter int DATA_W     = 24,
  parameter int AVG_LOG    = 2,
  parameter int CAL_SETTLE = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cal_start,
  input  logic                cal_rst,
  input  logic [DATA_W/8-1:0] ofs_we,
  input  logic [DATA_W/8-1:0] gain_we,
  input  logic [7:0]          wr_data,
  output logic                busy,
  output logic                cal_done,
  output logic                req_valid,
  input  logic                req_ready,
  output logic                req_phase,
  input  logic                res_valid,
  output logic                res_ready,
  input  logic [DATA_W-1:0]   res_data,
  output logic [DATA_W-1:0]   ofs_q,
  output logic [DATA_W-1:0]   gain_q
);
  localparam int NB    = DATA_W / 8;
  localparam int SET_W = $clog2(CAL_SETTLE + 1);

  cal_state_e        state;
  logic              phase_q;
  logic [SET_W-1:0]  set_cnt;
  logic [AVG_LOG-1:0] smp_cnt;
  logic              take;
  logic [DATA_W-1:0] avg;

  assign busy      = (state != CS_IDLE);
  assign req_valid = (state == CS_REQ);
  assign req_phase = phase_q;
  assign res_ready = (state == CS_WAIT);
  assign take      = res_valid && res_ready;
  assign cal_done  = (state == CS_STORE) && phase_q;

  cal_accum #(.DATA_W(DATA_W), .AVG_LOG(AVG_LOG)) u_accum (
    .clk(clk), .rst_n(rst_n),
    .clr(state == CS_SETTLE), .add_en(take),
    .signed_mode(!phase_q), .sample(res_data), .avg(avg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= CS_IDLE;
      phase_q <= 1'b0;
      set_cnt <= '0;
      smp_cnt <= '0;
      ofs_q   <= '0;
      gain_q  <= '0;
    end else begin
      case (state)
        CS_IDLE: begin
          if (cal_start) state <= CS_CLEAR;
          if (cal_rst) begin
            ofs_q  <= '0;
            gain_q <= '0;
          end else begin
            for (int b = 0; b < NB; b++) begin
              if (ofs_we[b])  ofs_q[8*b +: 8]  <= wr_data;
              if (gain_we[b]) gain_q[8*b +: 8] <= wr_data;
            end
          end
        end
        CS_CLEAR: begin
          ofs_q   <= '0;
          phase_q <= 1'b0;
          set_cnt <= '0;
          state   <= CS_SETTLE;
        end
        CS_SETTLE: begin
          smp_cnt <= '0;
          if (set_cnt == SET_W'(CAL_SETTLE - 1)) begin
            set_cnt <= '0;
            state   <= CS_REQ;
          end else begin
            set_cnt <= set_cnt + 1'b1;
          end
        end
        CS_REQ:  if (req_ready) state <= CS_WAIT;
        CS_WAIT: if (take) begin
          smp_cnt <= smp_cnt + 1'b1;
          state   <= (smp_cnt == '1) ? CS_STORE : CS_REQ;
        end
        CS_STORE: begin
          if (!phase_q) begin
            ofs_q   <= avg;
            phase_q <= 1'b1;
            state   <= CS_SETTLE;
          end else begin
            gain_q  <= avg;
            phase_q <= 1'b0;
            state   <= CS_IDLE;
          end
        end
        default: state <= CS_IDLE;
      endcase
    end
  end

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_phase)));
  p_ofs_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CS_SETTLE && !phase_q) |-> (ofs_q == '0));
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !busy);
  p_crst_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cal_rst |=> (ofs_q == '0 && gain_q == '0));
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
  import cal_seq_pkg::*;
#(
  parameter int AW         = 4,
  parameter int CMD_W      = 16,
  parameter int DATA_W     = 24,
  parameter int AVG_LOG    = 2,
  parameter int CAL_SETTLE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [1:0]        mode_o,
  output logic              lock_o,
  output logic              sleep_o,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] ofs_o,
  output logic [DATA_W-1:0] gain_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_phase_o,
  input  logic              res_valid_i,
  output logic              res_ready_o,
  input  logic [DATA_W-1:0] res_data_i
);
  localparam int NB = DATA_W / 8;

  logic          cal_start, cal_rst, cal_done, busy;
  logic [NB-1:0] ofs_we, gain_we;

  assign lock_o  = busy || cal_start;
  assign mode_o  = cmd_o[1:0];
  assign sleep_o = (cmd_o[1:0] == MODE_SLEEP);

  cal_regfile #(.AW(AW), .CMD_W(CMD_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lock(lock_o), .cal_done(cal_done),
    .cmd_q(cmd_o), .data_q(data_o), .cal_start(cal_start),
    .ofs_we(ofs_we), .gain_we(gain_we), .cal_rst(cal_rst)
  );

  cal_fsm #(.DATA_W(DATA_W), .AVG_LOG(AVG_LOG), .CAL_SETTLE(CAL_SETTLE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cal_rst(cal_rst),
    .ofs_we(ofs_we), .gain_we(gain_we), .wr_data(wr_data),
    .busy(busy), .cal_done(cal_done),
    .req_valid(req_valid_o), .req_ready(req_ready_i), .req_phase(req_phase_o),
    .res_valid(res_valid_i), .res_ready(res_ready_o), .res_data(res_data_i),
    .ofs_q(ofs_o), .gain_q(gain_o)
  );

  p_start_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> (lock_o && mode_o == MODE_CAL));
  p_sleep_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> !lock_o);
endmodule

// File: tb/cal_sequencer_bench.sv
module cal_sequencer_bench;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] cmd_o;
  logic [1:0]  mode_o;
  logic        lock_o, sleep_o;
  logic [23:0] data_o, ofs_o, gain_o;
  logic        req_valid_o, req_phase_o, res_ready_o;
  logic        req_ready_i = 1'b0;
  logic        res_valid_i = 1'b0;
  logic [23:0] res_data_i = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int round = 0;
  int ofs_idx = 0;
  int gain_idx = 0;
  int req_count = 0;
  bit exp_phase[$];

  int          ofs_smp [2][NS] = '{'{-5, -6, 3, -1}, '{7, 8, 9, 10}};
  logic [23:0] gain_smp[2][NS] = '{'{24'h800000, 24'h800003, 24'h7FFFFF, 24'h800001},
                                   '{24'h000001, 24'h000002, 24'h000003, 24'h000005}};

  always #5 clk = ~clk;

  cal_sequencer u_cal_sequencer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_o(cmd_o), .mode_o(mode_o), .lock_o(lock_o), .sleep_o(sleep_o),
    .data_o(data_o), .ofs_o(ofs_o), .gain_o(gain_o),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_phase_o(req_phase_o),
    .res_valid_i(res_valid_i), .res_ready_o(res_ready_o), .res_data_i(res_data_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [23:0] exp_ofs(input int r);
    int s = 0;
    for (int i = 0; i < NS; i++) s += ofs_smp[r][i];
    return 24'(s >>> 2);
  endfunction

  function automatic logic [23:0] exp_gain(input int r);
    longint s = 0;
    for (int i = 0; i < NS; i++) s += longint'(gain_smp[r][i]);
    return 24'(s >> 2);
  endfunction

  // Driver: loads the scoreboard with the expected request phases, then starts.
  task automatic start_cal(input int r);
    round = r; ofs_idx = 0; gain_idx = 0;
    for (int i = 0; i < NS; i++) exp_phase.push_back(1'b0);
    for (int i = 0; i < NS; i++) exp_phase.push_back(1'b1);
    wr(4'd0, 8'h11);
  endtask

  // Monitor and measurement responder.
  initial begin
    forever begin
      @(negedge clk);
      if (req_valid_o) begin
        bit ph;
        bit exp;
        ph = req_phase_o;
        repeat (2) @(negedge clk);
        chk("R12 request held while not ready", {30'd0, req_valid_o, req_phase_o}, {30'd0, 1'b1, ph});
        req_ready_i = 1'b1;
        @(negedge clk);
        req_ready_i = 1'b0;
        req_count++;
        if (exp_phase.size() == 0) begin
          chk("R5 unexpected extra request", 32'd1, 32'd0);
        end else begin
          exp = exp_phase.pop_front();
          chk("R5 request phase order", {31'd0, ph}, {31'd0, exp});
        end
        chk("R12 result ready while waiting", {31'd0, res_ready_o}, 32'd1);
        if (!ph) begin
          res_data_i = 24'(ofs_smp[round][ofs_idx]); ofs_idx++;
        end else begin
          res_data_i = gain_smp[round][gain_idx]; gain_idx++;
        end
        res_valid_i = 1'b1;
        @(negedge clk);
        res_valid_i = 1'b0;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_unlock();
    int n = 0;
    while (lock_o && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cmd", {16'd0, cmd_o}, 32'd0);
    chk("R1 data/ofs/gain", {8'd0, data_o | ofs_o | gain_o}, 32'd0);
    chk("R1 flags", {28'd0, mode_o, lock_o, sleep_o}, 32'd0);

    // R2 byte map
    wr(4'd2, 8'h12); wr(4'd3, 8'h34); wr(4'd4, 8'h56);
    chk("R2 data bytes", {8'd0, data_o}, 32'h563412);
    wr(4'd5, 8'hA1); wr(4'd6, 8'hA2); wr(4'd7, 8'hA3);
    wr(4'd8, 8'hB1); wr(4'd9, 8'hB2); wr(4'd10, 8'hB3);
    chk("R2 offset bytes", {8'd0, ofs_o}, 32'hA3A2A1);
    chk("R2 gain bytes", {8'd0, gain_o}, 32'hB3B2B1);
    wr(4'd1, 8'h5A);
    chk("R2 cmd high byte", {16'd0, cmd_o}, 32'h5A00);
    wr(4'd13, 8'hFF);
    chk("R2 unmapped address", {8'd0, data_o ^ ofs_o ^ gain_o}, {8'd0, 24'h563412 ^ 24'hA3A2A1 ^ 24'hB3B2B1});

    // R10 clear bit
    wr(4'd0, 8'h04);
    chk("R10 clear zeroes data", {8'd0, data_o}, 32'd0);
    wr(4'd2, 8'h77);
    chk("R10 data write ignored while clear", {8'd0, data_o}, 32'd0);
    wr(4'd0, 8'h00); wr(4'd2, 8'h77);
    chk("R10 data write after clear released", {8'd0, data_o}, 32'h77);

    // R11 calibration reset
    wr(4'd0, 8'h08);
    chk("R11 correction words zeroed", {8'd0, ofs_o | gain_o}, 32'd0);
    chk("R11 bit reads zero", {31'd0, cmd_o[3]}, 32'd0);

    // R3 mode 01 without sample/hold
    wr(4'd0, 8'h01);
    chk("R3 cal without sh stores normal", {30'd0, mode_o}, 32'd0);
    chk("R3 cal without sh no lock", {31'd0, lock_o}, 32'd0);

    // R9 sleep
    wr(4'd0, 8'h02);
    chk("R9 sleep entered", {30'd0, sleep_o, lock_o}, 32'h2);
    wr(4'd3, 8'h44);
    chk("R9 write accepted in sleep", {8'd0, data_o}, 32'h4477);
    wr(4'd1, 8'h00);
    chk("R9 high byte keeps sleep", {31'd0, sleep_o}, 32'd1);
    wr(4'd0, 8'h03);
    chk("R9 sleep left by mode 11", {29'd0, sleep_o, mode_o}, 32'h3);
    wr(4'd0, 8'h00);

    // Calibration round 0
    wr(4'd5, 8'h11); wr(4'd6, 8'h22); wr(4'd7, 8'h33);
    req_count = 0;
    start_cal(0);
    chk("R3 lock after start", {29'd0, lock_o, mode_o}, 32'h5);
    repeat (3) @(negedge clk);
    chk("R5 offset cleared first", {8'd0, ofs_o}, 32'd0);
    wr(4'd2, 8'hEE);
    wr(4'd0, 8'h02);
    chk("R4 lock still high", {31'd0, lock_o}, 32'd1);
    wait_unlock();
    chk("R8 done mode and lock", {29'd0, lock_o, mode_o}, 32'd0);
    chk("R8 sh kept", {16'd0, cmd_o}, 32'h0010);
    chk("R4 data untouched", {8'd0, data_o}, 32'h4477);
    chk("R4 sleep not entered", {31'd0, sleep_o}, 32'd0);
    chk("R6 signed offset average", {8'd0, ofs_o}, {8'd0, exp_ofs(0)});
    chk("R7 unsigned gain average", {8'd0, gain_o}, {8'd0, exp_gain(0)});
    chk("R5 request count", req_count, 2 * NS);
    chk("R5 scoreboard empty", exp_phase.size(), 0);

    // Calibration round 1
    req_count = 0;
    start_cal(1);
    wait_unlock();
    chk("R6 offset average round 1", {8'd0, ofs_o}, {8'd0, exp_ofs(1)});
    chk("R7 gain average round 1", {8'd0, gain_o}, {8'd0, exp_gain(1)});
    chk("R5 request count round 1", req_count, 2 * NS);
    wr(4'd2, 8'h99);
    chk("R4 writes accepted after unlock", {8'd0, data_o}, 32'h4499);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule